// File: doc/BRIEF.md
# GPU Token and Finish Interrupt Controller

This block sits between a graphics pipeline and a host processor and turns two pipeline events into level interrupt requests. A token event carries a 16-bit token value and a flag that says whether an interrupt is wanted. A frame-finish event marks the end of a drawn frame. The block keeps one pending flag for each of the two sources. It masks each flag with an enable bit and drives two registered interrupt lines. It also drives a 16-bit cause word, which a processor interrupt aggregator ORs into its own status.

The host reaches the block through a simple 16-bit register bus with two word addresses. The control register holds the two enables and two write-only clear strobes. The token register is read-only and returns the value of the most recent token event. Each event is first captured in a one-cycle staging register. While an event waits there, a "waiting" status output is high. In the next cycle the event is applied to the pending flags and to the token register.

Top module: `gpuirq_unit`

## Requirements
- R1: After reset, both registers read as 0x0000, `irqToken`, `irqFinish`, `irqCause`, `tokWaiting` and `finWaiting` are all 0.
- R2: The control register sits at word address `CTRL_ADDR` (default 0). Bit 0 is the token enable and bit 1 is the finish enable; both are read/write and read back as written. Bits 15:2 always read as 0, including the strobe bits 3:2.
- R3: Writing the control register with bit 2 set clears the token pending flag, and with bit 3 set clears the finish pending flag. The clear takes effect at the write's clock edge.
- R4: A token event sampled at edge E0 stores `tokVal` into the token register at edge E1 whatever `tokReq` is. The token register sits at word address `TOKEN_ADDR` (default 1).
- R5: A token event sets the token pending flag at E1 only when `tokReq` is 1. With `tokReq` 0 no token interrupt follows.
- R6: A finish event sampled at E0 always sets the finish pending flag at E1.
- R7: `irqToken` is a register loaded each edge with (token pending AND token enable); `irqFinish` follows the same rule with its own flag and enable. A change to a flag or an enable shows on the line one edge later.
- R8: In `irqCause`, bit 9 (0x200) mirrors `irqToken`, bit 10 (0x400) mirrors `irqFinish`, and every other bit is 0. With both sources active the word is 0x600.
- R9: Host writes to the token register address leave the token register unchanged.
- R10: `tokWaiting` / `finWaiting` go high at the edge that samples the matching event. Each drops at the next edge, when that event is applied, unless a further event arrives.
- R11: If a clear strobe and the application of an event for the same source fall on the same edge, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational, 0 when not reading |
| tokEvt | input | 1 | Token event pulse |
| tokVal | input | DATA_W | Token value carried by the event |
| tokReq | input | 1 | Token event asks for an interrupt |
| finEvt | input | 1 | Frame-finish event pulse |
| tokWaiting | output | 1 | Token event staged, not yet applied |
| finWaiting | output | 1 | Finish event staged, not yet applied |
| irqToken | output | 1 | Token interrupt line |
| irqFinish | output | 1 | Finish interrupt line |
| irqCause | output | CAUSE_W | Cause word for the aggregator |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, 4-bit word addresses with control at 0 and token at 1, and cause bits 9 and 10 in a 16-bit cause word. These values make the 0x200/0x400/0x600 cause patterns and the full upper half of the control word visible. They also expose the token register to host writes, so the read-only rule and the read-as-zero rule can be checked at the ports. The bench uses the same settings to place a clear strobe on exactly the edge where a staged event is applied, and to time the one-edge lag of the interrupt lines after an enable changes.

// File: rtl/gpuirq_pkg.sv
package gpuirq_pkg;

  // Control register bit positions (the host software decodes these)
  localparam int BIT_TOK_EN  = 0;
  localparam int BIT_FIN_EN  = 1;
  localparam int BIT_TOK_CLR = 2;
  localparam int BIT_FIN_CLR = 3;
  localparam int CTRL_USED_W = 4;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic ctrlWr;    // control register written this cycle
    logic tokEnNew;  // new token enable value
    logic finEnNew;  // new finish enable value
    logic tokClr;    // clear token pending
    logic finClr;    // clear finish pending
  } ctrlStrobes_t;

endpackage

// File: rtl/gpuirq_ctrl.sv
module gpuirq_ctrl
  import gpuirq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int CTRL_ADDR  = 0,
  parameter int TOKEN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              enTok,
  input  logic              enFin,
  input  logic [DATA_W-1:0] tokenReg,
  output ctrlStrobes_t      stb,
  output logic [DATA_W-1:0] busRdata
);

  localparam logic [ADDR_W-1:0] CtrlA  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] TokenA = ADDR_W'(TOKEN_ADDR);

  logic hitCtrl, hitToken, isRead, isWrite;
  logic unusedWdataHi;

  assign hitCtrl  = (busAddr == CtrlA);
  assign hitToken = (busAddr == TokenA);
  assign isRead   = busSel && !busWe;
  assign isWrite  = busSel && busWe;
  assign unusedWdataHi = ^busWdata[DATA_W-1:CTRL_USED_W];

  // Write decode: only the control register accepts writes
  always_comb begin
    stb          = '0;
    stb.ctrlWr   = isWrite && hitCtrl;
    stb.tokEnNew = busWdata[BIT_TOK_EN];
    stb.finEnNew = busWdata[BIT_FIN_EN];
    stb.tokClr   = isWrite && hitCtrl && busWdata[BIT_TOK_CLR];
    stb.finClr   = isWrite && hitCtrl && busWdata[BIT_FIN_CLR];
  end

  // Read mux: strobes and unused bits return zero
  always_comb begin
    busRdata = '0;
    if (isRead && hitCtrl) begin
      busRdata[BIT_TOK_EN] = enTok;
      busRdata[BIT_FIN_EN] = enFin;
    end else if (isRead && hitToken) begin
      busRdata = tokenReg;
    end
  end

  // R2
  ctrl_read_hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && hitCtrl) |-> (busRdata[DATA_W-1:BIT_FIN_EN+1] == '0));

  // R9
  token_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && hitToken && !hitCtrl) |-> !(stb.ctrlWr || stb.tokClr || stb.finClr));

endmodule

// File: rtl/gpuirq_datapath.sv
module gpuirq_datapath
  import gpuirq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CAUSE_W       = 16,
  parameter int TOK_CAUSE_BIT = 9,
  parameter int FIN_CAUSE_BIT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       stb,
  input  logic               tokEvt,
  input  logic [DATA_W-1:0]  tokVal,
  input  logic               tokReq,
  input  logic               finEvt,
  output logic               enTok,
  output logic               enFin,
  output logic [DATA_W-1:0]  tokenReg,
  output logic               tokWaiting,
  output logic               finWaiting,
  output logic               irqToken,
  output logic               irqFinish,
  output logic [CAUSE_W-1:0] irqCause
);

  logic              stTok, stTokReq, stFin;
  logic [DATA_W-1:0] stTokVal;
  logic              pendTok, pendFin;
  logic              tokApplySet;

  assign tokApplySet = stTok && stTokReq;

  // Event staging: one cycle between arrival and application
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stTok    <= 1'b0;
      stTokReq <= 1'b0;
      stTokVal <= '0;
      stFin    <= 1'b0;
    end else begin
      stTok <= tokEvt;
      stFin <= finEvt;
      if (tokEvt) begin
        stTokVal <= tokVal;
        stTokReq <= tokReq;
      end
    end
  end

  // Enables, token register, pending flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enTok    <= 1'b0;
      enFin    <= 1'b0;
      tokenReg <= '0;
      pendTok  <= 1'b0;
      pendFin  <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        enTok <= stb.tokEnNew;
        enFin <= stb.finEnNew;
      end
      if (stTok) tokenReg <= stTokVal;
      // an applied event outranks a clear on the same edge
      if (tokApplySet)     pendTok <= 1'b1;
      else if (stb.tokClr) pendTok <= 1'b0;
      if (stFin)           pendFin <= 1'b1;
      else if (stb.finClr) pendFin <= 1'b0;
    end
  end

  // Registered interrupt lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqToken  <= 1'b0;
      irqFinish <= 1'b0;
    end else begin
      irqToken  <= pendTok && enTok;
      irqFinish <= pendFin && enFin;
    end
  end

  always_comb begin
    irqCause                = '0;
    irqCause[TOK_CAUSE_BIT] = irqToken;
    irqCause[FIN_CAUSE_BIT] = irqFinish;
  end

  assign tokWaiting = stTok;
  assign finWaiting = stFin;

  // R10
  tok_waiting_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    tokEvt |=> tokWaiting);

  // R10
  fin_waiting_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finWaiting && !finEvt) |=> !finWaiting);

  // R3
  tok_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tokClr && !tokApplySet) |=> !pendTok);

  // R11
  tok_event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tokClr && tokApplySet) |=> pendTok);

  // R6
  fin_event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    finWaiting |=> pendFin);

  // R9
  token_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tokWaiting |=> $stable(tokenReg));

  // R7
  irq_tok_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqToken) |-> $past(pendTok));

endmodule

// File: rtl/gpuirq_unit.sv
module gpuirq_unit
  import gpuirq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 4,
  parameter int CTRL_ADDR     = 0,
  parameter int TOKEN_ADDR    = 1,
  parameter int CAUSE_W       = 16,
  parameter int TOK_CAUSE_BIT = 9,
  parameter int FIN_CAUSE_BIT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               tokEvt,
  input  logic [DATA_W-1:0]  tokVal,
  input  logic               tokReq,
  input  logic               finEvt,
  output logic               tokWaiting,
  output logic               finWaiting,
  output logic               irqToken,
  output logic               irqFinish,
  output logic [CAUSE_W-1:0] irqCause
);

  ctrlStrobes_t      stb;
  logic              enTok, enFin;
  logic [DATA_W-1:0] tokenReg;

  gpuirq_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .TOKEN_ADDR(TOKEN_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .enTok(enTok), .enFin(enFin), .tokenReg(tokenReg),
    .stb(stb), .busRdata(busRdata)
  );

  gpuirq_datapath #(
    .DATA_W(DATA_W), .CAUSE_W(CAUSE_W),
    .TOK_CAUSE_BIT(TOK_CAUSE_BIT), .FIN_CAUSE_BIT(FIN_CAUSE_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tokEvt(tokEvt), .tokVal(tokVal), .tokReq(tokReq), .finEvt(finEvt),
    .enTok(enTok), .enFin(enFin), .tokenReg(tokenReg),
    .tokWaiting(tokWaiting), .finWaiting(finWaiting),
    .irqToken(irqToken), .irqFinish(irqFinish), .irqCause(irqCause)
  );

  // R8
  cause_only_known_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqCause) == (32'(irqToken) + 32'(irqFinish)));

endmodule

// File: tb/gpuirq_unit_test.sv
`timescale 1ns/1ps
module gpuirq_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        tokEvt = 1'b0, tokReq = 1'b0, finEvt = 1'b0;
  logic [15:0] tokVal = '0;
  logic        tokWaiting, finWaiting, irqToken, irqFinish;
  logic [15:0] irqCause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpuirq_unit uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tokEvt(tokEvt), .tokVal(tokVal),
    .tokReq(tokReq), .finEvt(finEvt), .tokWaiting(tokWaiting), .finWaiting(finWaiting),
    .irqToken(irqToken), .irqFinish(irqFinish), .irqCause(irqCause)
  );

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_TOK  = 4'd1;

  // op: 0 write ctrl, 1 write token addr, 2 token evt no req, 3 token evt req, 4 finish evt
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [3:0]  rdAddr;
    logic [15:0] expRd;
    logic [15:0] expCause;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h0003, 4'd0, 16'h0003, 16'h0000, 8'd2},  // R2 enables read back
    '{3'd2, 16'h1234, 4'd1, 16'h1234, 16'h0000, 8'd5},  // R5 no request, R4 value
    '{3'd3, 16'hBEEF, 4'd1, 16'hBEEF, 16'h0200, 8'd4},  // R4 R8 token cause
    '{3'd4, 16'h0000, 4'd0, 16'h0003, 16'h0600, 8'd6},  // R6 R8 both
    '{3'd0, 16'h0007, 4'd0, 16'h0003, 16'h0400, 8'd3},  // R3 token clear, strobe reads 0
    '{3'd0, 16'h0001, 4'd0, 16'h0001, 16'h0000, 8'd7},  // R7 finish masked
    '{3'd0, 16'h0003, 4'd0, 16'h0003, 16'h0400, 8'd7},  // R7 pending kept
    '{3'd0, 16'h000B, 4'd0, 16'h0003, 16'h0000, 8'd3},  // R3 finish clear
    '{3'd1, 16'h5555, 4'd1, 16'hBEEF, 16'h0000, 8'd9},  // R9 token write ignored
    '{3'd0, 16'hFFF0, 4'd0, 16'h0000, 16'h0000, 8'd2},  // R2 upper bits read 0
    '{3'd3, 16'h0042, 4'd1, 16'h0042, 16'h0000, 8'd7},  // R7 disabled, R4 value
    '{3'd0, 16'h0001, 4'd0, 16'h0001, 16'h0200, 8'd7}   // R7 enable exposes pending
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [3:0] a, output logic [15:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  // drive on negedge, hold over one posedge
  task automatic doOp(input logic [2:0] op, input logic [15:0] data);
    @(negedge clk);
    case (op)
      3'd0: begin busSel = 1; busWe = 1; busAddr = A_CTRL; busWdata = data; end
      3'd1: begin busSel = 1; busWe = 1; busAddr = A_TOK;  busWdata = data; end
      3'd2: begin tokEvt = 1; tokReq = 0; tokVal = data; end
      3'd3: begin tokEvt = 1; tokReq = 1; tokVal = data; end
      default: finEvt = 1;
    endcase
    @(negedge clk);
    busSel = 0; busWe = 0; tokEvt = 0; tokReq = 0; finEvt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    doRead(A_CTRL, rd); check("R1 ctrl", rd, 16'h0000);
    doRead(A_TOK, rd);  check("R1 token", rd, 16'h0000);
    check("R1 cause", irqCause, 16'h0000);
    check("R1 waiting", {14'd0, tokWaiting, finWaiting}, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, VECS[i].data);
      @(negedge clk); @(negedge clk);
      check($sformatf("R%0d vec%0d cause", VECS[i].req, i), irqCause, VECS[i].expCause);
      check($sformatf("R8 vec%0d lines", i), {14'd0, irqFinish, irqToken},
            {14'd0, VECS[i].expCause[10], VECS[i].expCause[9]});
      doRead(VECS[i].rdAddr, rd);
      check($sformatf("R%0d vec%0d read", VECS[i].req, i), rd, VECS[i].expRd);
    end

    // R7 latency: token pending and enabled now; disable at edge E0
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = A_CTRL; busWdata = 16'h0000;
    @(negedge clk);  // after E0
    busSel = 0; busWe = 0;
    check("R7 old line after enable write", {15'd0, irqToken}, 16'h0001);
    @(negedge clk);  // after E1
    check("R7 line one edge later", {15'd0, irqToken}, 16'h0000);

    // R10 waiting timing
    @(negedge clk);
    tokEvt = 1; tokReq = 0; tokVal = 16'h7777; finEvt = 1;
    @(negedge clk);  // after E0
    tokEvt = 0; finEvt = 0;
    check("R10 waiting high", {14'd0, tokWaiting, finWaiting}, 16'h0003);
    doRead(A_TOK, rd); check("R10 token not yet applied", rd, 16'h0042);
    @(negedge clk);  // after E1
    check("R10 waiting dropped", {14'd0, tokWaiting, finWaiting}, 16'h0000);
    doRead(A_TOK, rd); check("R4 token applied", rd, 16'h7777);

    // clear everything, enable both
    doOp(3'd0, 16'h000F);
    @(negedge clk); @(negedge clk);
    check("R3 all cleared", irqCause, 16'h0000);

    // R11 clear strobe on the same edge as event application
    @(negedge clk);
    tokEvt = 1; tokReq = 1; tokVal = 16'hA5A5; finEvt = 1;
    @(negedge clk);  // after E0
    tokEvt = 0; tokReq = 0; finEvt = 0;
    busSel = 1; busWe = 1; busAddr = A_CTRL; busWdata = 16'h000F;
    @(negedge clk);  // after E1
    busSel = 0; busWe = 0;
    @(negedge clk);  // after E2
    check("R11 event wins over clear", irqCause, 16'h0600);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule